// File: doc/BRIEF.md
# Streaming Roberts Cross Edge Detector

This block takes a raster stream of 8-bit grey pixels, one pixel on each cycle where the input is marked valid, and produces one edge strength value per pixel using the Roberts cross operator over a 2x2 neighbourhood. The neighbourhood of the pixel being received is built from four values. The first is that pixel itself. The second is the previous pixel of the same row, held in a register. The third and fourth are the two pixels of the row above, at the same column and one column to the left.

The row above comes from one of two on-chip row memories. While the incoming row is written into one memory, the other memory, which holds the completed previous row, is read at the same column. At every end of line the two memories exchange roles. The edge strength is the larger of the two absolute diagonal differences. Positions that lack a full neighbourhood (the whole first row of a frame and the first pixel of every row) produce zero.

The result leaves the block a fixed two cycles after its pixel entered. It carries a valid flag and start-of-frame and end-of-line flags that are delayed by the same amount. Upstream marks the first pixel of a frame and the last pixel of each row. The block keeps no frame timing of its own, and idle cycles between pixels do not disturb it.

Top module: `roberts_edge_stream`

## Requirements
- R1: For a pixel d with left neighbour c, upper neighbour b and upper-left neighbour a, all unsigned 8-bit, edgeOut equals max(|d-a|, |b-c|). The result fits in 8 bits for every input, including 0 and 255 extremes.
- R2: A pixel accepted at a rising edge (pixValid high) produces edgeValid high in the output sampled after the second following rising edge. edgeValid is never high without such a pixel.
- R3: A valid pixel with pixEol high is the last pixel of its row. The next valid pixel is column 0 of the following row, and that row's upper neighbours are the pixels of the row just ended.
- R4: Every pixel of the first row of a frame gives edgeOut = 0. The first row is the row starting with the pixel flagged by pixSof.
- R5: The first pixel (column 0) of every row gives edgeOut = 0.
- R6: edgeSof and edgeEol repeat pixSof and pixEol of the same pixel with the same two-cycle delay, and are high only together with edgeValid.
- R7: When edgeValid is low, edgeOut is 0.
- R8: Rows of up to 512 pixels are processed correctly, including the pixel at column 511. All rows within one frame have equal width.
- R9: A pixel with pixSof high restarts the frame, even in the middle of a row. It is treated as column 0 of the first row.
- R10: While rstN is low and after its release, before any pixel, all outputs are 0.
- R11: Cycles with pixValid low do not advance the column, change stored pixels or alter later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 8 | Grey pixel value |
| pixValid | input | 1 | pixIn holds a pixel this cycle |
| pixSof | input | 1 | First pixel of a frame (qualified by pixValid) |
| pixEol | input | 1 | Last pixel of a row (qualified by pixValid) |
| edgeOut | output | 8 | Edge strength, 0 when not valid |
| edgeValid | output | 1 | edgeOut holds a result |
| edgeSof | output | 1 | Result belongs to the first pixel of a frame |
| edgeEol | output | 1 | Result belongs to the last pixel of a row |

## Verification
At the last pixel of a row, the write of that pixel into the current-row memory, the read of the memory above and the exchange of memory roles all happen on the same edge. The pixel that follows must then find the row just written. The bench provokes this by sending rows back to back with no idle cycle, and also with random gaps. It judges every output against a behavioural frame model, so any wrong bank or stale column shows up in the next row. A start of frame arriving in the middle of a row collides with the column count and the first-row state. That case is checked by aborting a frame part-way and requiring zero output for the whole new first row and correct values from its second row on.

// File: rtl/edge_pkg.sv
package edge_pkg;
  // strobes issued by the control for the pixel presented this cycle
  typedef struct packed {
    logic live;       // a pixel is accepted this cycle
    logic frameStart; // accepted pixel opens a frame
    logic lineEnd;    // accepted pixel closes a row
    logic blank;      // no full neighbourhood: force a zero result
    logic bankSel;    // index of the memory taking the current row
  } strobe_t;
endpackage

// File: rtl/edge_rowbank.sv
module edge_rowbank #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [PIX_W-1:0] wrData,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [PIX_W-1:0] rdData
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/edge_ctrl.sv
module edge_ctrl
  import edge_pkg::*;
#(
  parameter int unsigned LINE_MAX = 512,
  localparam int unsigned COL_W = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic             pixEol,
  output strobe_t          strb,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] colCnt;
  logic             firstRow;
  logic             wrBank;
  logic [COL_W-1:0] colEff;
  logic             firstEff;

  always_comb begin
    colEff          = pixSof ? '0 : colCnt;
    firstEff        = pixSof | firstRow;
    colAddr         = colEff;
    strb.live       = pixValid;
    strb.frameStart = pixValid & pixSof;
    strb.lineEnd    = pixValid & pixEol;
    strb.blank      = firstEff | (colEff == '0);
    strb.bankSel    = wrBank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt   <= '0;
      firstRow <= 1'b1;
      wrBank   <= 1'b0;
    end else if (pixValid) begin
      if (pixEol) begin
        colCnt   <= '0;
        firstRow <= 1'b0;
        wrBank   <= ~wrBank;
      end else begin
        colCnt   <= colEff + 1'b1;
        firstRow <= firstEff;
      end
    end
  end
endmodule

// File: rtl/edge_dpath.sv
module edge_dpath
  import edge_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LINE_MAX = 512,
  localparam int unsigned COL_W = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [COL_W-1:0] colAddr,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] edgeOut,
  output logic             edgeValid,
  output logic             edgeSof,
  output logic             edgeEol
);
  logic [PIX_W-1:0] rdData [2];
  logic [PIX_W-1:0] prevPix, aReg, s1D, s1C, bSample;
  logic             s1Live, s1Sof, s1Eol, s1Blank, s1Bank;
  logic [PIX_W-1:0] diagA, diagB, peak;

  for (genvar i = 0; i < 2; i++) begin : g_bank
    edge_rowbank #(.PIX_W(PIX_W), .DEPTH(LINE_MAX)) u_bank (
      .clk    (clk),
      .wrEn   (strb.live && (strb.bankSel == 1'(i))),
      .wrAddr (colAddr),
      .wrData (pixIn),
      .rdEn   (strb.live && (strb.bankSel != 1'(i))),
      .rdAddr (colAddr),
      .rdData (rdData[i])
    );
  end

  // stage 1: register the pixel, its left neighbour and the strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Live  <= 1'b0;
      s1Sof   <= 1'b0;
      s1Eol   <= 1'b0;
      s1Blank <= 1'b1;
      s1Bank  <= 1'b0;
      s1D     <= '0;
      s1C     <= '0;
      prevPix <= '0;
    end else begin
      s1Live  <= strb.live;
      s1Sof   <= strb.frameStart;
      s1Eol   <= strb.lineEnd;
      s1Blank <= strb.blank;
      s1Bank  <= strb.bankSel;
      if (strb.live) begin
        s1D     <= pixIn;
        s1C     <= prevPix;
        prevPix <= pixIn;
      end
    end
  end

  // the row above lives in the memory not being written
  assign bSample = s1Bank ? rdData[0] : rdData[1];

  function automatic logic [PIX_W-1:0] absDiff(input logic [PIX_W-1:0] x, input logic [PIX_W-1:0] y);
    return (x > y) ? x - y : y - x;
  endfunction

  always_comb begin
    diagA = absDiff(s1D, aReg);
    diagB = absDiff(bSample, s1C);
    peak  = (diagA > diagB) ? diagA : diagB;
  end

  // stage 2: result and delayed flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg      <= '0;
      edgeOut   <= '0;
      edgeValid <= 1'b0;
      edgeSof   <= 1'b0;
      edgeEol   <= 1'b0;
    end else begin
      if (s1Live) aReg <= bSample;
      edgeOut   <= (s1Live && !s1Blank) ? peak : '0;
      edgeValid <= s1Live;
      edgeSof   <= s1Sof;
      edgeEol   <= s1Eol;
    end
  end
endmodule

// File: rtl/roberts_edge_stream.sv
module roberts_edge_stream
  import edge_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LINE_MAX = 512,
  localparam int unsigned COL_W = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic             pixEol,
  output logic [PIX_W-1:0] edgeOut,
  output logic             edgeValid,
  output logic             edgeSof,
  output logic             edgeEol
);
  strobe_t          strb;
  logic [COL_W-1:0] colAddr;

  edge_ctrl #(.LINE_MAX(LINE_MAX)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pixValid (pixValid),
    .pixSof   (pixSof),
    .pixEol   (pixEol),
    .strb     (strb),
    .colAddr  (colAddr)
  );

  edge_dpath #(.PIX_W(PIX_W), .LINE_MAX(LINE_MAX)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .colAddr   (colAddr),
    .pixIn     (pixIn),
    .edgeOut   (edgeOut),
    .edgeValid (edgeValid),
    .edgeSof   (edgeSof),
    .edgeEol   (edgeEol)
  );
endmodule

// File: rtl/edge_checker.sv
module edge_checker #(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixValid,
  input logic             pixSof,
  input logic             pixEol,
  input logic [PIX_W-1:0] edgeOut,
  input logic             edgeValid,
  input logic             edgeSof,
  input logic             edgeEol
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (edgeValid == $past(pixValid, 2)));

  a_r4_sof_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixSof) |=> ##1 (edgeValid && edgeSof && edgeOut == '0));

  a_r6_eol_delay: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixEol) |=> ##1 (edgeValid && edgeEol));

  a_r6_flags_valid: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSof || edgeEol) |-> edgeValid);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !edgeValid |-> (edgeOut == '0));
endmodule

bind roberts_edge_stream edge_checker #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pixValid  (pixValid),
  .pixSof    (pixSof),
  .pixEol    (pixEol),
  .edgeOut   (edgeOut),
  .edgeValid (edgeValid),
  .edgeSof   (edgeSof),
  .edgeEol   (edgeEol)
);

// File: tb/test_roberts_edge_stream.sv
module test_roberts_edge_stream;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pixIn = '0;
  logic       pixValid = 1'b0, pixSof = 1'b0, pixEol = 1'b0;
  logic [7:0] edgeOut;
  logic       edgeValid, edgeSof, edgeEol;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    v;
    int    val;
    bit    s;
    bit    e;
    string tag;
  } exp_t;
  exp_t expQ[$];

  // behavioural frame model
  int    upRow[512];
  int    thisRow[512];
  int    mCol = 0;
  bit    mFirst = 1;
  int    mLeft = 0;
  string frameTag = "R1";

  roberts_edge_stream i_roberts_edge_stream (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid),
    .pixSof(pixSof), .pixEol(pixEol), .edgeOut(edgeOut),
    .edgeValid(edgeValid), .edgeSof(edgeSof), .edgeEol(edgeEol));

  always #2 clk = ~clk;

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int absv(int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic compare(exp_t x);
    checks++;
    if (edgeValid !== x.v || edgeSof !== x.s || edgeEol !== x.e || int'(edgeOut) != x.val) begin
      errors++;
      $display("FAIL %s: actual v=%0b s=%0b e=%0b out=%0d expected v=%0b s=%0b e=%0b out=%0d",
               x.tag, edgeValid, edgeSof, edgeEol, edgeOut, x.v, x.s, x.e, x.val);
    end
  endtask

  // one cycle: judge the output due now, then present the next input
  task automatic step(bit v, int p, bit s, bit e);
    exp_t x;
    @(negedge clk);
    if (expQ.size() == 2) compare(expQ.pop_front());
    pixValid = v;
    pixIn    = 8'(p);
    pixSof   = s;
    pixEol   = e;
    x.v = v; x.s = v & s; x.e = v & e; x.val = 0;
    if (!v) begin
      x.tag = "R7 R2";
    end else begin
      if (s) begin mCol = 0; mFirst = 1; end
      if (mFirst) begin
        x.tag = s ? "R4 R6" : "R4";
      end else if (mCol == 0) begin
        x.tag = "R5 R3";
      end else begin
        x.val = (absv(p - upRow[mCol-1]) > absv(upRow[mCol] - mLeft)) ?
                absv(p - upRow[mCol-1]) : absv(upRow[mCol] - mLeft);
        x.tag = e ? {frameTag, " R6"} : frameTag;
      end
      thisRow[mCol] = p;
      mLeft = p;
      if (e) begin
        upRow  = thisRow;
        mCol   = 0;
        mFirst = 0;
      end else begin
        mCol++;
      end
    end
    expQ.push_back(x);
  endtask

  task automatic sendFrame(int w, int h, int gapPct, bit extremes);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        int p;
        while (gapPct > 0 && int'($urandom_range(99)) < gapPct) step(0, 0, 0, 0);
        p = extremes ? (($urandom_range(1) == 1) ? 255 : 0) : int'($urandom_range(255));
        step(1, p, (r == 0 && c == 0), (c == w - 1));
      end
    end
  endtask

  initial begin
    // R10: outputs during reset
    repeat (3) @(negedge clk);
    checks++;
    if (edgeValid !== 1'b0 || edgeSof !== 1'b0 || edgeEol !== 1'b0 || edgeOut !== 8'd0) begin
      errors++;
      $display("FAIL R10: actual v=%0b s=%0b e=%0b out=%0d expected all zero",
               edgeValid, edgeSof, edgeEol, edgeOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (edgeValid !== 1'b0 || edgeOut !== 8'd0) begin
      errors++;
      $display("FAIL R10: after release actual v=%0b out=%0d expected 0 0", edgeValid, edgeOut);
    end

    frameTag = "R1";  sendFrame(8, 6, 0, 0);
    frameTag = "R11"; sendFrame(8, 4, 35, 0);
    frameTag = "R1";  sendFrame(12, 4, 10, 1);
    // R9: abort a frame in the middle of its third row
    frameTag = "R9";
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < ((r == 2) ? 5 : 10); c++)
        step(1, int'($urandom_range(255)), (r == 0 && c == 0), (c == 9));
    sendFrame(10, 4, 0, 0);
    // R8: full-width rows
    frameTag = "R8";  sendFrame(512, 3, 0, 0);
    repeat (3) step(0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule